// File: doc/BRIEF.md
# Programmable Clock Divider Bank

The bank turns one reference clock into three slower rates. Three integer dividers are chained in series. The first stage counts reference cycles. Each later stage counts the output ticks of the stage before it. For every stage the bank produces two outputs in the reference clock domain: a one-cycle tick, which serves as a clock enable, and a divided level, which has the shape of the divided clock.

Software sets up a stage through its divider register. The register holds a low-phase count, a high-phase count, an edge-select bit, a bypass bit and a no-update bit. The divide ratio is the sum of the two counts.

A write only stages its value. All three staged values become live together when software writes any divider register with the no-update bit clear. Each stage switches to its new setting only at the end of its current period, so a changeover never produces a short pulse. A status bit goes low when such a commit is written. It comes back high after every stage has switched and a fixed settling time has passed.

Top module: `clkdiv_bank`

## Requirements
- R1: Divider register k (k = 0, 1, 2) sits at byte address 4*k. Its field layout is: low count in bits [5:0], high count in [11:6], edge select in bit 12, bypass in bit 13, no-update in bit 14. Reading the register returns the last value written to it, with bits [31:15] read as zero.
- R2: After reset every stage is in bypass, the lock bit is 1, each divider register reads 0x2000, and all ticks and levels are 1.
- R3: A stage that is not bypassed and has a nonzero count sum N has a period of N input ticks. Its output tick fires on the first input tick of each period.
- R4: With edge select 0, the level of a divided stage is high for the first (high count) input ticks of a period and low for the rest. With edge select 1 it is high for the first (low count) input ticks.
- R5: A stage with the bypass bit set, or with both counts zero, copies its input tick and level to its outputs. The input of stage 0 is a tick on every reference cycle with a constant level of 1.
- R6: The input ticks of stage k+1 are the output ticks of stage k, so a later stage only ticks in a cycle in which every earlier stage ticks.
- R7: A divider write with no-update = 1 changes only the stored register value. The outputs keep running as before and lock stays 1.
- R8: A divider write with no-update = 0 commits the stored values of all three registers. Each stage takes on its new setting on the last input tick of its current period.
- R9: The status register at byte address 0x10 reports lock in bit 0. Lock is 0 from the cycle after a commit write until every stage has switched, and then for LOCK_CYCLES (16) further cycles. When all stages switch at once from bypass, lock is low for exactly LOCK_CYCLES + 3 cycles.
- R10: Reads of any other address return 0. Writes to any other address change no register, no output and no lock state.
- R11: If a second commit is written while an earlier one is still pending, the values of the second commit are the ones that take effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock |
| rstN | input | 1 | Asynchronous reset, active low |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | 8 | Byte address of the write |
| wrData | input | 15 | Write data (divider register fields) |
| rdAddr | input | 8 | Byte address of the combinational read |
| rdData | output | 32 | Read data |
| divTick | output | 3 | Per-stage period-start tick, stage 0 in bit 0 |
| divLvl | output | 3 | Per-stage divided level |
| lock | output | 1 | Reconfiguration finished |

## Verification
Some properties are checked on every cycle:
- Lock falls after every commit write.
- Lock stays high when no commit is written.
- Lock is never high while a stage still has a pending setting.
- A later stage never ticks without the stage before it.
- Unmapped reads return zero.

Other behaviour can only be shown through the bench scenarios, which compare the design on every cycle against a behavioural model. These scenarios cover the exact period lengths, the phase split chosen by the edge bit, the switch at period boundaries, the exact lock-low duration, and the rule that the newest commit wins.

// File: rtl/clkdiv_pkg.sv
package clkdiv_pkg;

  localparam int CNT_W = 6;

  // live settings of one stage
  typedef struct packed {
    logic             bypass;
    logic             edgeSel;
    logic [CNT_W-1:0] highCnt;
    logic [CNT_W-1:0] lowCnt;
  } divSet_t;

  // full divider register word
  typedef struct packed {
    logic    noUpd;
    divSet_t set;
  } divCfg_t;

  localparam int CFG_W = $bits(divCfg_t);

  localparam divSet_t SET_RESET = '{bypass: 1'b1, edgeSel: 1'b0, highCnt: '0, lowCnt: '0};
  localparam divCfg_t CFG_RESET = '{noUpd: 1'b0, set: SET_RESET};

  // strobes from control to datapath
  typedef struct packed {
    logic commit;
  } ctrlStb_t;

endpackage

// File: rtl/clkdiv_stage.sv
module clkdiv_stage
  import clkdiv_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    inTick,
  input  logic    inLvl,
  input  logic    loadValid,
  input  divSet_t loadSet,
  output logic    outTick,
  output logic    outLvl,
  output logic    loadTaken
);

  divSet_t          curQ;
  logic [CNT_W:0]   cntQ;
  logic [CNT_W:0]   span;
  logic [CNT_W:0]   firstLen;
  logic             passThru;
  logic             lastTick;

  always_comb begin
    span     = {1'b0, curQ.lowCnt} + {1'b0, curQ.highCnt};
    passThru = curQ.bypass || (span == '0);
    lastTick = passThru || (cntQ == span - 1'b1);
    firstLen = curQ.edgeSel ? {1'b0, curQ.lowCnt} : {1'b0, curQ.highCnt};
  end

  assign outTick   = passThru ? inTick : (inTick && (cntQ == '0));
  assign outLvl    = passThru ? inLvl  : (cntQ < firstLen);
  assign loadTaken = loadValid && inTick && lastTick;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      curQ <= SET_RESET;
      cntQ <= '0;
    end else if (loadTaken) begin
      curQ <= loadSet;
      cntQ <= '0;
    end else if (inTick) begin
      cntQ <= lastTick ? '0 : cntQ + 1'b1;
    end
  end

endmodule

// File: rtl/clkdiv_bank_dp.sv
module clkdiv_bank_dp
  import clkdiv_pkg::*;
#(
  parameter int NUM_DIV = 3
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  ctrlStb_t                stb,
  input  divSet_t [NUM_DIV-1:0]   divSet,
  output logic                    busy,
  output logic [NUM_DIV-1:0]      divTick,
  output logic [NUM_DIV-1:0]      divLvl
);

  logic [NUM_DIV:0]      tickChain;
  logic [NUM_DIV:0]      lvlChain;
  logic [NUM_DIV-1:0]    pendQ;
  logic [NUM_DIV-1:0]    taken;
  divSet_t [NUM_DIV-1:0] pendSetQ;

  assign tickChain[0] = 1'b1;
  assign lvlChain[0]  = 1'b1;

  for (genvar g = 0; g < NUM_DIV; g++) begin : g_stage
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        pendQ[g]    <= 1'b0;
        pendSetQ[g] <= SET_RESET;
      end else if (stb.commit) begin
        pendQ[g]    <= 1'b1;
        pendSetQ[g] <= divSet[g];
      end else if (taken[g]) begin
        pendQ[g]    <= 1'b0;
      end
    end

    clkdiv_stage u_stage (
      .clk       (clk),
      .rstN      (rstN),
      .inTick    (tickChain[g]),
      .inLvl     (lvlChain[g]),
      .loadValid (pendQ[g]),
      .loadSet   (pendSetQ[g]),
      .outTick   (tickChain[g+1]),
      .outLvl    (lvlChain[g+1]),
      .loadTaken (taken[g])
    );
  end

  assign busy    = |pendQ;
  assign divTick = tickChain[NUM_DIV:1];
  assign divLvl  = lvlChain[NUM_DIV:1];

endmodule

// File: rtl/clkdiv_bank_ctrl.sv
module clkdiv_bank_ctrl
  import clkdiv_pkg::*;
#(
  parameter int NUM_DIV     = 3,
  parameter int ADDR_W      = 8,
  parameter int DATA_W      = 32,
  parameter int LOCK_CYCLES = 16,
  parameter int STATUS_ADDR = 16
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  wrEn,
  input  logic [ADDR_W-1:0]     wrAddr,
  input  logic [CFG_W-1:0]      wrData,
  input  logic [ADDR_W-1:0]     rdAddr,
  output logic [DATA_W-1:0]     rdData,
  input  logic                  busy,
  output divSet_t [NUM_DIV-1:0] divSet,
  output ctrlStb_t              stb,
  output logic                  lock
);

  localparam int LCK_W = $clog2(LOCK_CYCLES + 1);

  typedef enum logic [1:0] {ST_LOCKED, ST_WAIT, ST_SETTLE} lockSt_t;

  divCfg_t              shadowQ [NUM_DIV];
  logic [NUM_DIV-1:0]   wrHit;
  divCfg_t              wrCfg;
  logic                 commitWr;
  ctrlStb_t             stbQ;
  lockSt_t              stQ;
  logic [LCK_W-1:0]     settleQ;

  assign wrCfg = divCfg_t'(wrData);

  for (genvar i = 0; i < NUM_DIV; i++) begin : g_reg
    assign wrHit[i] = wrEn && (wrAddr == ADDR_W'(4 * i));

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)        shadowQ[i] <= CFG_RESET;
      else if (wrHit[i]) shadowQ[i] <= wrCfg;
    end

    assign divSet[i] = shadowQ[i].set;
  end

  assign commitWr = (|wrHit) && !wrCfg.noUpd;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) stbQ <= '0;
    else       stbQ.commit <= commitWr;
  end
  assign stb = stbQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stQ     <= ST_LOCKED;
      settleQ <= '0;
    end else if (commitWr) begin
      stQ     <= ST_WAIT;
      settleQ <= '0;
    end else begin
      case (stQ)
        ST_WAIT: begin
          if (!busy && !stbQ.commit) begin
            stQ     <= ST_SETTLE;
            settleQ <= '0;
          end
        end
        ST_SETTLE: begin
          if (settleQ == LCK_W'(LOCK_CYCLES - 1)) stQ <= ST_LOCKED;
          else                                     settleQ <= settleQ + 1'b1;
        end
        default: stQ <= ST_LOCKED;
      endcase
    end
  end

  assign lock = (stQ == ST_LOCKED);

  always_comb begin
    rdData = '0;
    for (int i = 0; i < NUM_DIV; i++) begin
      if (rdAddr == ADDR_W'(4 * i)) rdData[CFG_W-1:0] = shadowQ[i];
    end
    if (rdAddr == ADDR_W'(STATUS_ADDR)) rdData[0] = lock;
  end

endmodule

// File: rtl/clkdiv_bank.sv
module clkdiv_bank
  import clkdiv_pkg::*;
#(
  parameter int NUM_DIV     = 3,
  parameter int ADDR_W      = 8,
  parameter int DATA_W      = 32,
  parameter int LOCK_CYCLES = 16,
  parameter int STATUS_ADDR = 16
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               wrEn,
  input  logic [ADDR_W-1:0]  wrAddr,
  input  logic [CFG_W-1:0]   wrData,
  input  logic [ADDR_W-1:0]  rdAddr,
  output logic [DATA_W-1:0]  rdData,
  output logic [NUM_DIV-1:0] divTick,
  output logic [NUM_DIV-1:0] divLvl,
  output logic               lock
);

  ctrlStb_t              stb;
  divSet_t [NUM_DIV-1:0] divSet;
  logic                  busy;

  clkdiv_bank_ctrl #(
    .NUM_DIV     (NUM_DIV),
    .ADDR_W      (ADDR_W),
    .DATA_W      (DATA_W),
    .LOCK_CYCLES (LOCK_CYCLES),
    .STATUS_ADDR (STATUS_ADDR)
  ) u_ctrl (
    .clk    (clk),
    .rstN   (rstN),
    .wrEn   (wrEn),
    .wrAddr (wrAddr),
    .wrData (wrData),
    .rdAddr (rdAddr),
    .rdData (rdData),
    .busy   (busy),
    .divSet (divSet),
    .stb    (stb),
    .lock   (lock)
  );

  clkdiv_bank_dp #(
    .NUM_DIV (NUM_DIV)
  ) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .stb     (stb),
    .divSet  (divSet),
    .busy    (busy),
    .divTick (divTick),
    .divLvl  (divLvl)
  );

endmodule

// File: rtl/clkdiv_bank_chk.sv
module clkdiv_bank_chk #(
  parameter int NUM_DIV     = 3,
  parameter int ADDR_W      = 8,
  parameter int DATA_W      = 32,
  parameter int CFG_W       = 15,
  parameter int STATUS_ADDR = 16
) (
  input logic               clk,
  input logic               rstN,
  input logic               wrEn,
  input logic [ADDR_W-1:0]  wrAddr,
  input logic [CFG_W-1:0]   wrData,
  input logic [ADDR_W-1:0]  rdAddr,
  input logic [DATA_W-1:0]  rdData,
  input logic [NUM_DIV-1:0] divTick,
  input logic               lock,
  input logic               busy
);

  logic commitWr;
  logic rdMapped;

  assign commitWr = wrEn && (wrAddr < ADDR_W'(4 * NUM_DIV)) && (wrAddr[1:0] == 2'b00)
                    && !wrData[CFG_W-1];
  assign rdMapped = ((rdAddr < ADDR_W'(4 * NUM_DIV)) && (rdAddr[1:0] == 2'b00))
                    || (rdAddr == ADDR_W'(STATUS_ADDR));

  // R9: a commit write takes lock down on the next cycle
  p_lock_drop_r9: assert property (@(posedge clk) disable iff (!rstN) commitWr |=> !lock);

  // R7: without a commit write an asserted lock stays asserted
  p_lock_hold_r7: assert property (@(posedge clk) disable iff (!rstN) (lock && !commitWr) |=> lock);

  // R9: no lock while any stage still waits to switch
  p_pend_unlocked_r9: assert property (@(posedge clk) disable iff (!rstN) busy |-> !lock);

  // R10: unmapped reads are zero
  p_unmapped_zero_r10: assert property (@(posedge clk) disable iff (!rstN) !rdMapped |-> (rdData == '0));

  // R6: a later stage ticks only together with the stage before it
  for (genvar k = 0; k + 1 < NUM_DIV; k++) begin : g_casc
    p_cascade_r6: assert property (@(posedge clk) disable iff (!rstN) divTick[k+1] |-> divTick[k]);
  end

endmodule

bind clkdiv_bank clkdiv_bank_chk #(
  .NUM_DIV     (NUM_DIV),
  .ADDR_W      (ADDR_W),
  .DATA_W      (DATA_W),
  .CFG_W       (clkdiv_pkg::CFG_W),
  .STATUS_ADDR (STATUS_ADDR)
) u_chk (
  .clk     (clk),
  .rstN    (rstN),
  .wrEn    (wrEn),
  .wrAddr  (wrAddr),
  .wrData  (wrData),
  .rdAddr  (rdAddr),
  .rdData  (rdData),
  .divTick (divTick),
  .lock    (lock),
  .busy    (busy)
);

// File: tb/clkdiv_bank_bench.sv
module clkdiv_bank_bench;

  localparam int LOCK = 16;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic [7:0]  wrAddr = '0;
  logic [14:0] wrData = '0;
  logic [7:0]  rdAddr = '0;
  logic [31:0] rdData;
  logic [2:0]  divTick;
  logic [2:0]  divLvl;
  logic        lock;

  always #10 clk = ~clk;

  clkdiv_bank u_clkdiv_bank (
    .clk     (clk),
    .rstN    (rstN),
    .wrEn    (wrEn),
    .wrAddr  (wrAddr),
    .wrData  (wrData),
    .rdAddr  (rdAddr),
    .rdData  (rdData),
    .divTick (divTick),
    .divLvl  (divLvl),
    .lock    (lock)
  );

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  bit modelOn = 1'b0;

  task automatic check(string tag, longint act, longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // register word for ratio n (R1 layout)
  function automatic logic [14:0] enc(int n, bit commit);
    logic [14:0] v;
    v = '0;
    v[14]   = !commit;
    v[13]   = (n == 1);
    v[12]   = n[0];
    v[5:0]  = n[0] ? 6'((n >> 1) + 1) : 6'(n >> 1);
    v[11:6] = 6'(n >> 1);
    return v;
  endfunction

  // behavioural reference model
  int          mCnt[3]     = '{0, 0, 0};
  logic [13:0] mAct[3]     = '{14'h2000, 14'h2000, 14'h2000};
  logic [13:0] mPendSet[3] = '{14'h2000, 14'h2000, 14'h2000};
  logic [14:0] mShadow[3]  = '{15'h2000, 15'h2000, 15'h2000};
  bit          mPend[3]    = '{0, 0, 0};
  bit          mStbQ = 1'b0;
  int          mState = 0;
  int          mSettle = 0;

  function automatic void evalModel(output logic [2:0] t, output logic [2:0] l,
                                    output logic [2:0] ti, output logic [2:0] ap);
    bit tin;
    bit lin;
    tin = 1'b1;
    lin = 1'b1;
    for (int s = 0; s < 3; s++) begin
      int n;
      int first;
      bit byp;
      n     = int'(mAct[s][5:0]) + int'(mAct[s][11:6]);
      byp   = mAct[s][13] || (n == 0);
      first = mAct[s][12] ? int'(mAct[s][5:0]) : int'(mAct[s][11:6]);
      ti[s] = tin;
      if (byp) begin
        t[s] = tin;
        l[s] = lin;
      end else begin
        t[s] = tin && (mCnt[s] == 0);
        l[s] = (mCnt[s] < first);
      end
      ap[s] = mPend[s] && tin && (byp || mCnt[s] == n - 1);
      tin = t[s];
      lin = l[s];
    end
  endfunction

  always @(posedge clk) begin : model
    logic [2:0] t, l, ti, ap;
    bit busyPre, stbPre, commitW;
    int idx;
    if (!rstN) begin
      for (int s = 0; s < 3; s++) begin
        mCnt[s] = 0; mAct[s] = 14'h2000; mPendSet[s] = 14'h2000;
        mShadow[s] = 15'h2000; mPend[s] = 1'b0;
      end
      mStbQ = 1'b0; mState = 0; mSettle = 0;
    end else begin
      evalModel(t, l, ti, ap);
      busyPre = mPend[0] || mPend[1] || mPend[2];
      stbPre  = mStbQ;
      for (int s = 0; s < 3; s++) begin
        int n;
        n = int'(mAct[s][5:0]) + int'(mAct[s][11:6]);
        if (ap[s]) begin
          mAct[s] = mPendSet[s]; mCnt[s] = 0; mPend[s] = 1'b0;
        end else if (ti[s]) begin
          if (mAct[s][13] || n == 0 || mCnt[s] == n - 1) mCnt[s] = 0;
          else mCnt[s] = mCnt[s] + 1;
        end
      end
      if (stbPre) begin
        for (int s = 0; s < 3; s++) begin
          mPend[s] = 1'b1; mPendSet[s] = mShadow[s][13:0];
        end
      end
      idx = (wrEn && wrAddr[1:0] == 2'b00 && wrAddr < 8'd12) ? int'(wrAddr >> 2) : -1;
      commitW = (idx >= 0) && !wrData[14];
      if (commitW) begin
        mState = 1; mSettle = 0;
      end else if (mState == 1) begin
        if (!busyPre && !stbPre) begin mState = 2; mSettle = 0; end
      end else if (mState == 2) begin
        if (mSettle == LOCK - 1) mState = 0;
        else mSettle = mSettle + 1;
      end
      if (idx >= 0) mShadow[idx] = wrData;
      mStbQ = commitW;
    end
  end

  // per-cycle comparison against the model
  always @(negedge clk) begin : compare
    logic [2:0] t, l, ti, ap;
    if (modelOn) begin
      evalModel(t, l, ti, ap);
      check("R3 tick vs model", divTick, t);
      check("R4 level vs model", divLvl, l);
      check("R9 lock vs model", lock, mState == 0);
    end
  end

  task automatic wr(logic [7:0] a, logic [14:0] d);
    @(negedge clk);
    wrEn = 1'b1; wrAddr = a; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic rd(logic [7:0] a, logic [31:0] exp, string tag);
    @(negedge clk);
    rdAddr = a;
    #1;
    check(tag, rdData, exp);
  endtask

  task automatic waitLock(output int n);
    n = 0;
    while (!lock && n < 5000) begin
      @(negedge clk);
      n++;
    end
  endtask

  task automatic period(int s, output int p);
    int guard;
    guard = 0;
    do begin @(negedge clk); guard++; end while (!divTick[s] && guard < 5000);
    p = 0;
    do begin @(negedge clk); p++; end while (!divTick[s] && p < 5000);
  endtask

  task automatic highLen0(output int h);
    int guard;
    guard = 0;
    do begin @(negedge clk); guard++; end while (!divTick[0] && guard < 5000);
    h = 0;
    while (divLvl[0] && h < 5000) begin
      h++;
      @(negedge clk);
    end
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL R9 watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin : main
    int p, n;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    modelOn = 1'b1;
    @(negedge clk);

    // R2 reset state
    check("R2 ticks", divTick, 3'b111);
    check("R2 levels", divLvl, 3'b111);
    check("R2 lock", lock, 1);
    rd(8'd0, 32'h2000, "R2 reg0");
    rd(8'd4, 32'h2000, "R2 reg1");
    rd(8'd8, 32'h2000, "R2 reg2");
    rd(8'h10, 32'h1, "R9 status");

    // R1 / R7 staged writes
    wr(8'd0, enc(4, 0));
    wr(8'd4, enc(3, 0));
    check("R7 lock after staging", lock, 1);
    check("R7 ticks after staging", divTick, 3'b111);
    rd(8'd0, {17'b0, enc(4, 0)}, "R1 readback reg0");
    rd(8'd4, {17'b0, enc(3, 0)}, "R1 readback reg1");

    // R8 commit, R9 lock timing
    wr(8'd8, enc(2, 1));
    check("R9 lock drop", lock, 0);
    waitLock(n);
    check("R9 lock low cycles", n, LOCK + 3);
    period(0, p); check("R3 stage0 period", p, 4);
    period(1, p); check("R6 stage1 period", p, 12);
    period(2, p); check("R6 stage2 period", p, 24);

    // R7 staged write leaves running outputs alone
    wr(8'd0, enc(5, 0));
    repeat (20) @(negedge clk);
    check("R7 lock held", lock, 1);
    period(0, p); check("R7 stage0 period unchanged", p, 4);

    // R8 commit through another register picks up staged stage0
    wr(8'd8, enc(2, 1));
    waitLock(n);
    period(0, p); check("R8 stage0 new period", p, 5);
    period(1, p); check("R8 stage1 period", p, 15);
    highLen0(n);  check("R4 edge1 high length", n, 3);

    // R4 edge 0 with odd split
    wr(8'd0, 15'h0083);
    waitLock(n);
    highLen0(n);  check("R4 edge0 high length", n, 2);
    period(0, p); check("R4 period", p, 5);

    // R5 bypass middle stage, then zero-sum last stage
    wr(8'd4, enc(1, 0));
    wr(8'd8, enc(3, 1));
    waitLock(n);
    period(1, p); check("R5 bypass stage1 period", p, 5);
    period(2, p); check("R5 stage2 period", p, 15);
    wr(8'd8, 15'h0000);
    waitLock(n);
    period(2, p); check("R5 zero-sum stage2 period", p, 5);

    // R11 newest commit wins
    wr(8'd0, enc(6, 1));
    wr(8'd0, enc(2, 1));
    waitLock(n);
    period(0, p); check("R11 stage0 period", p, 2);
    rd(8'd0, {17'b0, enc(2, 1)}, "R11 readback");

    // R10 unmapped accesses
    wr(8'd12, 15'h0005);
    check("R10 lock after unmapped write", lock, 1);
    rd(8'd0, {17'b0, enc(2, 1)}, "R10 reg0 unchanged");
    rd(8'd12, 32'h0, "R10 unmapped read 0x0c");
    rd(8'h20, 32'h0, "R10 unmapped read 0x20");
    period(0, p); check("R10 stage0 period unchanged", p, 2);

    repeat (50) @(negedge clk);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule